// File: doc/BRIEF.md
# Configurable Systolic Processing-Element Array

A rectangular grid of small 8-bit processing elements, each with a registered output. An element takes two operands: one from the element above it and one from the element to its left. It sends its single registered result both to the element on its right and to the element below it. Each element holds a 4-bit operation code that selects one of sixteen arithmetic or logic functions. The functions include wrapping and saturating sums, doubling, halving, averaging, pass-through, min/max and clipped differences.

Operand streams enter along the top row (one lane per column) and along the left column (one lane per row). The results of the rightmost column are the block's outputs. The outputs of the bottom row go nowhere.

The operation codes are loaded one whole column per write. A single strobe carries a column index and one code per row, so any mix of elements in that column can change together. Elements outside the addressed column keep their codes. Inside each element the datapath has two stages. The first stage forms a carry-extended sum and a borrow-extended difference from the operands. The second stage picks the result from the operands, the sum and the difference.

Top module: `pe_grid_top`

## Requirements
- R1: The element at row r, column c registers f(code, N, W) on every rising clock edge. N is the registered output of element (r-1, c), or for row 0 the north lane c, `north_in[8c+7:8c]`. W is the registered output of element (r, c-1), or for column 0 the west lane r, `west_in[8r+7:8r]`. The east lane r, `east_out[8r+7:8r]`, is the output of element (r, COLS-1).
- R2: Codes 0, 1 and 2 give N+W, 2N and 2W respectively, each taken modulo 256.
- R3: Codes 3, 4 and 5 give the same three sums, limited to 255.
- R4: Code 6 gives (N+W)>>1, taken from the 9-bit sum including its carry. Code 7 gives 255.
- R5: Codes 8, 9, 10 and 11 give N>>1, W>>1, N and W respectively.
- R6: Codes 12, 13, 14 and 15 give max(N,W), min(N,W), max(N-W,0) and max(W-N,0) respectively.
- R7: When `cfg_valid` is high at a rising edge, element (r, `cfg_col`) loads `cfg_codes[4r+3:4r]`. The result registered on the following edge uses the new code.
- R8: An element keeps its code at every edge where `cfg_valid` is low or `cfg_col` names another column, whatever `cfg_codes` carries.
- R9: While `rst_n` is low, and up to the second rising edge after it rises, every output is 0 and every code is 10. The third rising edge after the release is the first normal update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| north_in | input | COLS*DW | Top-edge operand, lane c feeds column c |
| west_in | input | ROWS*DW | Left-edge operand, lane r feeds row r |
| cfg_valid | input | 1 | Column code write strobe |
| cfg_col | input | COLW | Column addressed by the write |
| cfg_codes | input | ROWS*4 | New codes, lane r for row r |
| east_out | output | ROWS*DW | Registered results of the rightmost column, lane r from row r |

## Verification
The bench builds the array with 3 rows and 4 columns. The unequal sizes mean that any mix-up between rows and columns, or between north and west lanes, changes the east outputs. At this size the bench can give every one of the sixteen codes to the whole grid in turn. For each code it sweeps all 256 top-edge values against sixteen left-edge values, which covers the saturation, carry and borrow corners in about 66 thousand cycles. A random phase then interleaves column writes, strobe-low cycles carrying garbage codes, and random operand streams. A cycle model of the whole grid checks every east lane on every cycle.

// File: rtl/pe_grid_pkg.sv
package pe_grid_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_DBLN  = 4'd1,
    OP_DBLW  = 4'd2,
    OP_ADDS  = 4'd3,
    OP_DBLNS = 4'd4,
    OP_DBLWS = 4'd5,
    OP_AVG   = 4'd6,
    OP_ONES  = 4'd7,
    OP_HALFN = 4'd8,
    OP_HALFW = 4'd9,
    OP_PASSN = 4'd10,
    OP_PASSW = 4'd11,
    OP_MAX   = 4'd12,
    OP_MIN   = 4'd13,
    OP_SUBNW = 4'd14,
    OP_SUBWN = 4'd15
  } pe_op_e;

  localparam int OPW = 4;
  localparam pe_op_e RESET_OP = OP_PASSN;
endpackage

// File: rtl/pe_rst_sync.sv
module pe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/pe_front.sv
module pe_front
  import pe_grid_pkg::*;
#(
  parameter int DW = 8
) (
  input  pe_op_e        op,
  input  logic [DW-1:0] n,
  input  logic [DW-1:0] w,
  output logic [DW:0]   sum,
  output logic [DW:0]   diff
);
  logic [DW-1:0] opa;
  logic [DW-1:0] opb;

  always_comb begin
    unique case (op)
      OP_DBLN, OP_DBLNS: begin opa = n; opb = n; end
      OP_DBLW, OP_DBLWS: begin opa = w; opb = w; end
      default:           begin opa = n; opb = w; end
    endcase
  end

  assign sum  = {1'b0, opa} + {1'b0, opb};
  assign diff = {1'b0, n} - {1'b0, w};
endmodule

// File: rtl/pe_back.sv
module pe_back
  import pe_grid_pkg::*;
#(
  parameter int DW = 8
) (
  input  pe_op_e        op,
  input  logic [DW-1:0] n,
  input  logic [DW-1:0] w,
  input  logic [DW:0]   sum,
  input  logic [DW:0]   diff,
  output logic [DW-1:0] res
);
  logic n_below_w;
  assign n_below_w = diff[DW];

  always_comb begin
    unique case (op)
      OP_ADD, OP_DBLN, OP_DBLW:    res = sum[DW-1:0];
      OP_ADDS, OP_DBLNS, OP_DBLWS: res = sum[DW] ? {DW{1'b1}} : sum[DW-1:0];
      OP_AVG:   res = sum[DW:1];
      OP_ONES:  res = {DW{1'b1}};
      OP_HALFN: res = n >> 1;
      OP_HALFW: res = w >> 1;
      OP_PASSN: res = n;
      OP_PASSW: res = w;
      OP_MAX:   res = n_below_w ? w : n;
      OP_MIN:   res = n_below_w ? n : w;
      OP_SUBNW: res = n_below_w ? '0 : diff[DW-1:0];
      OP_SUBWN: res = n_below_w ? (DW'(0) - diff[DW-1:0]) : '0;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/pe_cell.sv
module pe_cell
  import pe_grid_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [OPW-1:0] cfg_op,
  input  logic [DW-1:0]  n,
  input  logic [DW-1:0]  w,
  output logic [DW-1:0]  q,
  output logic [OPW-1:0] op_q
);
  pe_op_e        code_q;
  pe_op_e        code_d;
  logic [DW:0]   sum;
  logic [DW:0]   diff;
  logic [DW-1:0] res;
  logic [DW-1:0] q_d;

  pe_front #(.DW(DW)) u_front (
    .op(code_q), .n(n), .w(w), .sum(sum), .diff(diff)
  );

  pe_back #(.DW(DW)) u_back (
    .op(code_q), .n(n), .w(w), .sum(sum), .diff(diff), .res(res)
  );

  always_comb begin
    code_d = code_q;
    if (cfg_we) code_d = pe_op_e'(cfg_op);
    q_d = res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RESET_OP;
      q      <= '0;
    end else begin
      code_q <= code_d;
      q      <= q_d;
    end
  end

  assign op_q = code_q;
endmodule

// File: rtl/pe_grid_top.sv
module pe_grid_top
  import pe_grid_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 8,
  localparam int COLW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COLS*DW-1:0]  north_in,
  input  logic [ROWS*DW-1:0]  west_in,
  input  logic                cfg_valid,
  input  logic [COLW-1:0]     cfg_col,
  input  logic [ROWS*OPW-1:0] cfg_codes,
  output logic [ROWS*DW-1:0]  east_out
);
  localparam int NCELL = ROWS * COLS;

  logic                 rst_i_n;
  logic [NCELL*DW-1:0]  q_flat;
  logic [NCELL*OPW-1:0] code_flat;
  logic [COLS-1:0]      col_we;

  pe_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  for (genvar c = 0; c < COLS; c++) begin : g_colwe
    assign col_we[c] = cfg_valid && (cfg_col == COLW'(c));
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [DW-1:0] n_op;
      logic [DW-1:0] w_op;

      if (r == 0) begin : g_ntop
        assign n_op = north_in[c*DW +: DW];
      end else begin : g_nin
        assign n_op = q_flat[((r-1)*COLS + c)*DW +: DW];
      end

      if (c == 0) begin : g_wedge
        assign w_op = west_in[r*DW +: DW];
      end else begin : g_win
        assign w_op = q_flat[(r*COLS + c - 1)*DW +: DW];
      end

      pe_cell #(.DW(DW)) u_cell (
        .clk    (clk),
        .rst_n  (rst_i_n),
        .cfg_we (col_we[c]),
        .cfg_op (cfg_codes[r*OPW +: OPW]),
        .n      (n_op),
        .w      (w_op),
        .q      (q_flat[(r*COLS + c)*DW +: DW]),
        .op_q   (code_flat[(r*COLS + c)*OPW +: OPW])
      );
    end
    assign east_out[r*DW +: DW] = q_flat[(r*COLS + COLS - 1)*DW +: DW];
  end
endmodule

// File: rtl/pe_grid_chk.sv
module pe_grid_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 8,
  parameter int COLW = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_valid,
  input logic [COLW-1:0]        cfg_col,
  input logic [ROWS*4-1:0]      cfg_codes,
  input logic [ROWS*COLS*4-1:0] code_flat,
  input logic [DW-1:0]          n00,
  input logic [DW-1:0]          w00,
  input logic [DW-1:0]          out00
);
  logic [3:0] code00;
  assign code00 = code_flat[3:0];

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      assert_cfg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cfg_valid) && ($past(cfg_col) == COLW'(c))
        |-> code_flat[(r*COLS + c)*4 +: 4] == $past(cfg_codes[r*4 +: 4]));

      assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(cfg_valid) && ($past(cfg_col) == COLW'(c)))
        |-> $stable(code_flat[(r*COLS + c)*4 +: 4]));
    end
  end

  assert_sat_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(code00) == 4'd3)
    |-> (out00 >= $past(n00)) && (out00 >= $past(w00)));

  assert_const_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(code00) == 4'd7) |-> (out00 == {DW{1'b1}}));

  assert_pass_north_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(code00) == 4'd10) |-> (out00 == $past(n00)));

  assert_min_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(code00) == 4'd13)
    |-> (out00 <= $past(n00)) && (out00 <= $past(w00)));
endmodule

bind pe_grid_top pe_grid_chk #(
  .ROWS(ROWS), .COLS(COLS), .DW(DW), .COLW(COLW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .cfg_valid (cfg_valid),
  .cfg_col   (cfg_col),
  .cfg_codes (cfg_codes),
  .code_flat (code_flat),
  .n00       (north_in[DW-1:0]),
  .w00       (west_in[DW-1:0]),
  .out00     (q_flat[DW-1:0])
);

// File: tb/sim_pe_grid_top.sv
module sim_pe_grid_top;
  localparam int NR = 3;
  localparam int NC = 4;
  localparam int DW = 8;
  localparam int CW = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NC*DW-1:0]  north;
  logic [NR*DW-1:0]  west;
  logic              cfg_valid;
  logic [CW-1:0]     cfg_col;
  logic [NR*4-1:0]   cfg_codes;
  logic [NR*DW-1:0]  east;

  int checks = 0;
  int errors = 0;
  bit mdl_en = 0;
  bit done = 0;
  string tag = "R9";

  int mq [NR][NC];
  int mc [NR][NC];

  always #4 clk = ~clk;

  pe_grid_top #(.ROWS(NR), .COLS(NC), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .north_in(north), .west_in(west),
    .cfg_valid(cfg_valid), .cfg_col(cfg_col), .cfg_codes(cfg_codes),
    .east_out(east)
  );

  function automatic int fop(int op, int n, int w);
    case (op)
      0:  return (n + w) % 256;
      1:  return (2 * n) % 256;
      2:  return (2 * w) % 256;
      3:  return (n + w > 255) ? 255 : n + w;
      4:  return (2 * n > 255) ? 255 : 2 * n;
      5:  return (2 * w > 255) ? 255 : 2 * w;
      6:  return (n + w) / 2;
      7:  return 255;
      8:  return n / 2;
      9:  return w / 2;
      10: return n;
      11: return w;
      12: return (n > w) ? n : w;
      13: return (n < w) ? n : w;
      14: return (n > w) ? n - w : 0;
      default: return (w > n) ? w - n : 0;
    endcase
  endfunction

  initial begin
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        mq[r][c] = 0;
        mc[r][c] = 10;
      end
  end

  always @(posedge clk) begin
    int nq [NR][NC];
    if (mdl_en) begin
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++) begin
          int nv;
          int wv;
          nv = (r == 0) ? int'(north[c*DW +: DW]) : mq[r-1][c];
          wv = (c == 0) ? int'(west[r*DW +: DW]) : mq[r][c-1];
          nq[r][c] = fop(mc[r][c], nv, wv);
        end
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++) mq[r][c] = nq[r][c];
      if (cfg_valid)
        for (int r = 0; r < NR; r++) mc[r][cfg_col] = int'(cfg_codes[r*4 +: 4]);
    end
  end

  task automatic check_east();
    for (int r = 0; r < NR; r++) begin
      checks++;
      if (int'(east[r*DW +: DW]) != mq[r][NC-1]) begin
        errors++;
        $display("FAIL %s lane %0d: actual %0d expected %0d", tag, r,
                 east[r*DW +: DW], mq[r][NC-1]);
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_east();
  endtask

  task automatic write_all(int op);
    for (int c = 0; c < NC; c++) begin
      cfg_valid = 1'b1;
      cfg_col   = CW'(c);
      for (int r = 0; r < NR; r++) cfg_codes[r*4 +: 4] = 4'(op);
      step();
    end
    cfg_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    north = '0;
    west = '0;
    cfg_valid = 1'b0;
    cfg_col = '0;
    cfg_codes = '0;
    // R9: outputs clear during reset and through the synchronizer window
    repeat (3) @(negedge clk);
    check_east();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    mdl_en = 1'b1;

    // R9: default code passes the north operand down each column
    tag = "R9";
    for (int i = 0; i < 12; i++) begin
      north = NC*DW'($urandom);
      west  = NR*DW'($urandom);
      step();
    end

    // R2 R3 R4 R5 R6: the whole grid on one code, dense operand sweep
    for (int op = 0; op < 16; op++) begin
      if (op < 3) tag = "R2";
      else if (op < 6) tag = "R3";
      else if (op < 8) tag = "R4";
      else if (op < 12) tag = "R5";
      else tag = "R6";
      write_all(op);
      for (int n = 0; n < 256; n++)
        for (int k = 0; k < 16; k++) begin
          int w;
          w = (k == 15) ? 255 : k * 17 + (n % 17);
          if (w > 255) w = 255;
          for (int c = 0; c < NC; c++) north[c*DW +: DW] = DW'(n + 53 * c);
          for (int r = 0; r < NR; r++) west[r*DW +: DW] = DW'(w ^ (r * 91));
          step();
        end
    end

    // R1 R7 R8: mixed per-column writes, ignored garbage, random streams
    tag = "R1 R7 R8";
    for (int i = 0; i < 20000; i++) begin
      cfg_valid = (($urandom % 4) == 0);
      cfg_col   = CW'($urandom);
      cfg_codes = NR*4'($urandom);
      north = NC*DW'($urandom);
      west  = NR*DW'($urandom);
      step();
    end
    cfg_valid = 1'b0;
    for (int i = 0; i < 8; i++) step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule